// File: doc/BRIEF.md
# RGB Composite Video Level Encoder

This block sits in front of a triple video DAC. On every rising pixel clock edge it captures three 8-bit colour samples together with the blanking, sync and forced-white controls. One clock later it presents one integer level code per colour channel, in DAC LSB units. Each code is built from up to three terms: a pixel term, a black pedestal that lifts picture black above the blanking level, and, on green only, a sync component. A downstream DAC model or checker turns the codes into currents.

The captured controls are kept as a registered level state. The six states are LV_SYNC_TIP (blank and sync both active), LV_BLANK (blank active, sync inactive), LV_PIX_NOSYNC and LV_PIX (picture data, with sync active or inactive), and LV_WHITE_NOSYNC and LV_WHITE (forced white, with sync active or inactive). Transitions are unconditional. Each edge moves from any state to the state picked by the newly captured controls. Reset enters LV_SYNC_TIP. The controls take effect in a fixed order. Blank removes the pixel term and the pedestal. Forced white replaces the pixel data. Sync only adds or removes its own component and overrides nothing.

Top module: `vid_level_enc`

## Requirements
- R1: Pixel data and all three controls are captured on the same rising edge, and all three output codes change together exactly one clock later.
- R2: With blank_n=1 and ref_white=0, red and blue equal the captured 8-bit straight-binary value (bit 0 = LSB) plus the pedestal.
- R3: With blank_n=0, red and blue are 0, whatever the pixel data and ref_white.
- R4: With blank_n=1 and ref_white=1, every channel uses a pixel term of 255, the same as data FFh, whatever the pixel data.
- R5: The pedestal (parameter PEDESTAL, default 21) is added on every channel whenever blank_n=1, so data 00h gives the black level 21 on red and blue.
- R6: When SYNC_ON_GREEN=1 (the default) and sync_n=1, green carries an extra SYNC_OFFSET (default 110). Red and blue never carry it.
- R7: Sync overrides nothing. With blank_n=1 and sync_n=0, green equals its pixel term plus the pedestal.
- R8: With blank_n=0 and sync_n=0, all three codes are 0 (the sync tip).
- R9: A synchronous reset (rst=1) drives all three codes to 0 at the next edge.
- R10: With blank_n=0 and sync_n=1, green equals SYNC_OFFSET (110), the blanking level on green.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pix_red | input | 8 | Red pixel sample |
| pix_grn | input | 8 | Green pixel sample |
| pix_blu | input | 8 | Blue pixel sample |
| blank_n | input | 1 | Blanking control, active low |
| sync_n | input | 1 | Sync control, low removes the sync component |
| ref_white | input | 1 | Forces the white level, active high |
| lvl_red | output | 10 | Red level code |
| lvl_grn | output | 10 | Green level code |
| lvl_blu | output | 10 | Blue level code |

## Verification
A wrong level state shows on the very next cycle as a misplaced pedestal, an absent or extra sync offset on green, or a white code where data was expected. The state is rebuilt from the inputs on every edge, so an error lasts only as long as the bad state and does not spread. A stale pixel register shows up as codes that lag their controls by one cycle. This is caught because the inputs change on every clock and each cycle is compared against the reference model.

// File: rtl/vid_level_pkg.sv
package vid_level_pkg;

    typedef enum logic [2:0] {
        LV_SYNC_TIP,
        LV_BLANK,
        LV_PIX_NOSYNC,
        LV_PIX,
        LV_WHITE_NOSYNC,
        LV_WHITE
    } lvl_state_e;

    typedef struct packed {
        logic video_on;
        logic white_on;
        logic sync_on;
    } lvl_flags_t;

endpackage

// File: rtl/vid_ctrl_fsm.sv
module vid_ctrl_fsm
    import vid_level_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       blank_n,
    input  logic       sync_n,
    input  logic       ref_white,
    output lvl_flags_t flags
);

    lvl_state_e state_q;
    lvl_state_e state_d;

    // next level state from the controls presented this cycle
    always_comb begin
        unique case ({blank_n, ref_white, sync_n})
            3'b000:  state_d = LV_SYNC_TIP;
            3'b010:  state_d = LV_SYNC_TIP;
            3'b001:  state_d = LV_BLANK;
            3'b011:  state_d = LV_BLANK;
            3'b100:  state_d = LV_PIX_NOSYNC;
            3'b101:  state_d = LV_PIX;
            3'b110:  state_d = LV_WHITE_NOSYNC;
            3'b111:  state_d = LV_WHITE;
            default: state_d = LV_SYNC_TIP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LV_SYNC_TIP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            LV_SYNC_TIP:     flags = '{video_on: 1'b0, white_on: 1'b0, sync_on: 1'b0};
            LV_BLANK:        flags = '{video_on: 1'b0, white_on: 1'b0, sync_on: 1'b1};
            LV_PIX_NOSYNC:   flags = '{video_on: 1'b1, white_on: 1'b0, sync_on: 1'b0};
            LV_PIX:          flags = '{video_on: 1'b1, white_on: 1'b0, sync_on: 1'b1};
            LV_WHITE_NOSYNC: flags = '{video_on: 1'b1, white_on: 1'b1, sync_on: 1'b0};
            LV_WHITE:        flags = '{video_on: 1'b1, white_on: 1'b1, sync_on: 1'b1};
            default:         flags = '{video_on: 1'b0, white_on: 1'b0, sync_on: 1'b0};
        endcase
    end

endmodule

// File: rtl/vid_chan_enc.sv
module vid_chan_enc
    import vid_level_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int CODE_W      = 10,
    parameter int PEDESTAL    = 21,
    parameter int SYNC_OFFSET = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pix_in,
    input  lvl_flags_t        flags,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] FULL_C = CODE_W'((1 << DATA_W) - 1);
    localparam logic [CODE_W-1:0] PED_C  = CODE_W'(PEDESTAL);
    localparam logic [CODE_W-1:0] SYNC_C = CODE_W'(SYNC_OFFSET);

    logic [DATA_W-1:0] pix_q;
    logic [CODE_W-1:0] pix_term;
    logic [CODE_W-1:0] video_term;
    logic [CODE_W-1:0] sync_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            pix_q <= '0;
        end else begin
            pix_q <= pix_in;
        end
    end

    always_comb begin
        pix_term   = flags.white_on ? FULL_C : CODE_W'(pix_q);
        video_term = flags.video_on ? (pix_term + PED_C) : '0;
        sync_term  = flags.sync_on ? SYNC_C : '0;
        code       = video_term + sync_term;
    end

endmodule

// File: rtl/vid_level_enc.sv
module vid_level_enc
    import vid_level_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int CODE_W        = 10,
    parameter int PEDESTAL      = 21,
    parameter int SYNC_OFFSET   = 110,
    parameter int SYNC_ON_GREEN = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pix_red,
    input  logic [DATA_W-1:0] pix_grn,
    input  logic [DATA_W-1:0] pix_blu,
    input  logic              blank_n,
    input  logic              sync_n,
    input  logic              ref_white,
    output logic [CODE_W-1:0] lvl_red,
    output logic [CODE_W-1:0] lvl_grn,
    output logic [CODE_W-1:0] lvl_blu
);

    localparam int NUM_CH = 3;
    localparam int GRN_CH = 1;

    lvl_flags_t        flags;
    logic [DATA_W-1:0] pix_arr  [NUM_CH];
    logic [CODE_W-1:0] code_arr [NUM_CH];

    assign pix_arr[0] = pix_red;
    assign pix_arr[1] = pix_grn;
    assign pix_arr[2] = pix_blu;

    vid_ctrl_fsm u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .blank_n   (blank_n),
        .sync_n    (sync_n),
        .ref_white (ref_white),
        .flags     (flags)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        localparam int CH_SYNC = (ch == GRN_CH && SYNC_ON_GREEN != 0) ? SYNC_OFFSET : 0;
        vid_chan_enc #(
            .DATA_W      (DATA_W),
            .CODE_W      (CODE_W),
            .PEDESTAL    (PEDESTAL),
            .SYNC_OFFSET (CH_SYNC)
        ) u_enc (
            .clk    (clk),
            .rst    (rst),
            .pix_in (pix_arr[ch]),
            .flags  (flags),
            .code   (code_arr[ch])
        );
    end

    assign lvl_red = code_arr[0];
    assign lvl_grn = code_arr[1];
    assign lvl_blu = code_arr[2];

endmodule

// File: rtl/vid_level_enc_chk.sv
module vid_level_enc_chk #(
    parameter int DATA_W        = 8,
    parameter int CODE_W        = 10,
    parameter int PEDESTAL      = 21,
    parameter int SYNC_OFFSET   = 110,
    parameter int SYNC_ON_GREEN = 1
) (
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] pix_red,
    input logic [DATA_W-1:0] pix_grn,
    input logic [DATA_W-1:0] pix_blu,
    input logic              blank_n,
    input logic              sync_n,
    input logic              ref_white,
    input logic [CODE_W-1:0] lvl_red,
    input logic [CODE_W-1:0] lvl_grn,
    input logic [CODE_W-1:0] lvl_blu
);

    localparam logic [CODE_W-1:0] PED_C   = CODE_W'(PEDESTAL);
    localparam logic [CODE_W-1:0] WHITE_C = CODE_W'((1 << DATA_W) - 1 + PEDESTAL);
    localparam logic [CODE_W-1:0] GSYNC_C = (SYNC_ON_GREEN != 0) ? CODE_W'(SYNC_OFFSET) : '0;

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (lvl_red == '0 && lvl_grn == '0 && lvl_blu == '0)); // R9

    AST_BLANK_RB_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(blank_n)) |-> (lvl_red == '0 && lvl_blu == '0)); // R3

    AST_SYNC_TIP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(blank_n) && !$past(sync_n))
        |-> (lvl_red == '0 && lvl_grn == '0 && lvl_blu == '0)); // R8

    AST_WHITE_RB: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blank_n) && $past(ref_white))
        |-> (lvl_red == WHITE_C && lvl_blu == WHITE_C)); // R4

    AST_PIX_RB: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blank_n) && !$past(ref_white))
        |-> (lvl_red == CODE_W'($past(pix_red)) + PED_C
             && lvl_blu == CODE_W'($past(pix_blu)) + PED_C)); // R2

    AST_GRN_PIX: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(blank_n) && !$past(ref_white))
        |-> (lvl_grn == CODE_W'($past(pix_grn)) + PED_C + ($past(sync_n) ? GSYNC_C : '0))); // R6

    AST_GRN_BLANK: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(blank_n) && $past(sync_n)) |-> (lvl_grn == GSYNC_C)); // R10

endmodule

bind vid_level_enc vid_level_enc_chk #(
    .DATA_W        (DATA_W),
    .CODE_W        (CODE_W),
    .PEDESTAL      (PEDESTAL),
    .SYNC_OFFSET   (SYNC_OFFSET),
    .SYNC_ON_GREEN (SYNC_ON_GREEN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_red   (pix_red),
    .pix_grn   (pix_grn),
    .pix_blu   (pix_blu),
    .blank_n   (blank_n),
    .sync_n    (sync_n),
    .ref_white (ref_white),
    .lvl_red   (lvl_red),
    .lvl_grn   (lvl_grn),
    .lvl_blu   (lvl_blu)
);

// File: tb/vid_level_enc_test.sv
module vid_level_enc_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix_red = '0, pix_grn = '0, pix_blu = '0;
    logic       blank_n = 1'b0, sync_n = 1'b0, ref_white = 1'b0;
    logic [9:0] lvl_red, lvl_grn, lvl_blu;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // pending expectation for the next sample
    bit    pend = 0;
    int    exp_r, exp_g, exp_b;
    string tag_rb, tag_g;

    always #10 clk = ~clk;

    vid_level_enc uut (
        .clk(clk), .rst(rst),
        .pix_red(pix_red), .pix_grn(pix_grn), .pix_blu(pix_blu),
        .blank_n(blank_n), .sync_n(sync_n), .ref_white(ref_white),
        .lvl_red(lvl_red), .lvl_grn(lvl_grn), .lvl_blu(lvl_blu)
    );

    function automatic int model(int d, bit bl_n, bit sy_n, bit wh, bit is_green);
        int v;
        if (!bl_n) v = 0;
        else v = (wh ? 255 : d) + 21;
        if (is_green && sy_n) v = v + 110;
        return v;
    endfunction

    task automatic check_one(string tag, string ch, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s channel %s: actual %0d expected %0d", tag, ch, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b,
                        input bit bl_n, input bit sy_n, input bit wh, input bit rs);
        @(negedge clk);
        if (pend) begin
            check_one(tag_rb, "red",   int'(lvl_red), exp_r);
            check_one(tag_g,  "green", int'(lvl_grn), exp_g);
            check_one(tag_rb, "blue",  int'(lvl_blu), exp_b);
        end
        rst = rs; pix_red = r; pix_grn = g; pix_blu = b;
        blank_n = bl_n; sync_n = sy_n; ref_white = wh;
        if (rs) begin
            exp_r = 0; exp_g = 0; exp_b = 0;
            tag_rb = "R9"; tag_g = "R9";
        end else begin
            exp_r = model(int'(r), bl_n, sy_n, wh, 1'b0);
            exp_g = model(int'(g), bl_n, sy_n, wh, 1'b1);
            exp_b = model(int'(b), bl_n, sy_n, wh, 1'b0);
            if (!bl_n && !sy_n) tag_rb = "R1,R8";
            else if (!bl_n)     tag_rb = "R1,R3";
            else if (wh)        tag_rb = "R1,R4";
            else if (r == 8'h00) tag_rb = "R1,R5";
            else                tag_rb = "R1,R2";
            if (!bl_n && !sy_n) tag_g = "R8";
            else if (!bl_n)     tag_g = "R10";
            else if (!sy_n)     tag_g = "R7";
            else                tag_g = "R6";
        end
        pend = 1;
    endtask

    initial begin
        // reset state (R9)
        repeat (3) step(8'h5A, 8'hA5, 8'h3C, 1'b1, 1'b1, 1'b1, 1'b1);
        // every control combination at 00h, FFh and random data; back-to-back cycles (R1)
        for (int pat = 0; pat < 6; pat++) begin
            for (int c = 0; c < 8; c++) begin
                logic [7:0] r, g, b;
                case (pat)
                    0: begin r = 8'h00; g = 8'h00; b = 8'h00; end
                    1: begin r = 8'hFF; g = 8'hFF; b = 8'hFF; end
                    default: begin r = 8'($urandom); g = 8'($urandom); b = 8'($urandom); end
                endcase
                step(r, g, b, c[2], c[1], c[0], 1'b0);
            end
        end
        // blank ignores white and data (R3), then an immediate return to picture (R1)
        step(8'h80, 8'h01, 8'hFE, 1'b0, 1'b1, 1'b1, 1'b0);
        step(8'h80, 8'h01, 8'hFE, 1'b1, 1'b0, 1'b0, 1'b0);
        // mid-stream reset with white requested (R9)
        step(8'h12, 8'h34, 8'h56, 1'b1, 1'b1, 1'b1, 1'b1);
        step(8'h12, 8'h34, 8'h56, 1'b1, 1'b1, 1'b0, 1'b0);
        step(8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        check_one(tag_rb, "red",   int'(lvl_red), exp_r);
        check_one(tag_g,  "green", int'(lvl_grn), exp_g);
        check_one(tag_rb, "blue",  int'(lvl_blu), exp_b);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule